// File: doc/BRIEF.md
# Display Plane Descriptor Fetcher

This block keeps the settings of one graphics display plane up to date from a chain of descriptors held in memory. Software does not program the plane directly. It writes the address of a descriptor into a next-node register. At every field-start event the block reads the sixteen words of that descriptor through a word-read memory port that uses a valid/ready request and a response strobe. It collects the plane settings into a shadow copy and then moves them to the output registers in a single cycle.

Each descriptor carries a link to the next one. After a load the next-node register takes that link, so a pair of descriptors that point at each other makes the plane alternate between a top-field and a bottom-field setup without further help from software. Software can redirect the chain at any time with one register write. A zero address stops the chain. A misaligned address is refused and is recorded in a sticky error flag.

Top module: `plane_desc_fetch`

## Requirements
- R1: After reset every plane output is zero, `plane_enable` is low, the next-node register reads 0, and the status register reads 0.
- R2: A fetch issues exactly 16 read requests at base, base+4, ..., base+60, in ascending order. Only one read is outstanding at a time. A request that is not accepted keeps `mem_req_valid` high and holds its address.
- R3: A field-start event while the next-node register is zero issues no memory request and leaves the outputs unchanged.
- R4: A field-start event while the next-node register has any of bits 3:0 set issues no request and sets the sticky error flag, status bit 1. Writing the status register at offset 0x00 with bit 1 set clears the flag.
- R5: When a descriptor finishes loading, the next-node register takes the descriptor's link word (word 9), unless R10 applies.
- R6: Word mapping from the descriptor: 0 drives `plane_ctrl`, 1 `plane_alpha`, 3 `plane_origin`, 4 `plane_stop`, 5 `plane_base`, 6 `plane_pitch`, 7 bits 26:16 `plane_height` and bits 10:0 `plane_width`, 10 `plane_key1`, 11 `plane_key2`, 13 `plane_props`, 15 `plane_clut`. Words 2, 8, 12 and 14 are discarded.
- R7: The plane outputs change only in a commit cycle, and all of them change together. They never show a partly loaded descriptor.
- R8: If bit 31 of word 0 is clear, the loaded settings commit when the fetch completes. If it is set, they commit at the clock edge that samples the next field-start event.
- R9: `plane_enable` is high after a commit whose word 13 has bits 1:0 equal to 00, and low otherwise.
- R10: A write to the next-node register (offset 0x24) during a fetch does not abort that fetch. The written value replaces the link word when the fetch completes.
- R11: A field-start event that arrives during a fetch does not start a second fetch.
- R12: `reg_rdata` shows the register addressed by `reg_addr` one cycle later. Offset 0x24 returns the next-node value. Offset 0x00 returns bit 0 = fetch in progress and bit 1 = error flag.
- R13: `plane_bottom` shows the field tag (`field_bottom`) that was sampled when the committed descriptor's fetch started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for reg_addr |
| field_start | input | 1 | One-cycle field-start event |
| field_bottom | input | 1 | Tag of the starting field: 1 = bottom field |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | 32 | Byte address of the requested word |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| plane_ctrl | output | 32 | Control word |
| plane_alpha | output | 32 | Alpha gain word |
| plane_origin | output | 32 | Viewport origin, line number in the upper half and pixel number in the lower half |
| plane_stop | output | 32 | Viewport stop, packed the same way as the origin |
| plane_base | output | 32 | Pixel memory base address |
| plane_pitch | output | 32 | Line pitch in bytes |
| plane_height | output | 11 | Source height |
| plane_width | output | 11 | Source width |
| plane_key1 | output | 32 | Colour key low bound |
| plane_key2 | output | 32 | Colour key high bound |
| plane_props | output | 32 | Plane properties word |
| plane_clut | output | 32 | Colour-table location |
| plane_enable | output | 1 | Plane shown to the mixer |
| plane_bottom | output | 1 | Field tag of the committed settings |

## Verification
The assertions check on every cycle that an unaccepted request holds its address, that a fetch never runs from a zero or misaligned base, that the outputs move only in commit cycles and stay put when a commit is deferred, that an enabled plane never carries an ignore bit, and that the next-node register and error flag change only for their stated causes. The bench scenarios are needed to show the values themselves. These are the word-to-output mapping, the ascending address sequence, the link-following chain between two descriptors, a write that redirects the chain in the middle of a fetch, and a deferred commit that lands exactly on the next field-start edge.

// File: rtl/pdf_pkg.sv
package pdf_pkg;

  localparam int DW    = 32;
  localparam int DIM_W = 11;
  localparam int H_LSB = 16;
  localparam int IGN_W = 2;

  // descriptor word indices (sequence fixed by the memory layout)
  localparam int W_CTRL  = 0;
  localparam int W_ALPHA = 1;
  localparam int W_VPO   = 3;
  localparam int W_VPS   = 4;
  localparam int W_PML   = 5;
  localparam int W_PITCH = 6;
  localparam int W_SIZE  = 7;
  localparam int W_LINK  = 9;
  localparam int W_KEY1  = 10;
  localparam int W_KEY2  = 11;
  localparam int W_PROPS = 13;
  localparam int W_CLUT  = 15;

  localparam int DEFER_BIT = 31;

  // register offsets and status bits
  localparam int REG_STATUS = 'h00;
  localparam int REG_NEXT   = 'h24;
  localparam int ST_BUSY    = 0;
  localparam int ST_ERR     = 1;

  typedef enum logic [2:0] {
    F_IDLE,
    F_ISSUE,
    F_WAIT,
    F_STORE,
    F_ADVANCE,
    F_DONE
  } fetch_state_e;

  typedef struct packed {
    logic [DW-1:0]    ctrl;
    logic [DW-1:0]    alpha;
    logic [DW-1:0]    origin;
    logic [DW-1:0]    stop;
    logic [DW-1:0]    base;
    logic [DW-1:0]    pitch;
    logic [DIM_W-1:0] height;
    logic [DIM_W-1:0] width;
    logic [DW-1:0]    key1;
    logic [DW-1:0]    key2;
    logic [DW-1:0]    props;
    logic [DW-1:0]    clut;
  } plane_cfg_t;

endpackage

// File: rtl/pdf_regs.sv
module pdf_regs
  import pdf_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int REG_AW     = 8,
  parameter int ALIGN_BITS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              field_start,
  input  logic              busy,
  input  logic              done,
  input  logic [ADDR_W-1:0] link,
  output logic [ADDR_W-1:0] next_node,
  output logic              start
);

  logic              err_q;
  logic              hold_q;
  logic [ADDR_W-1:0] hold_addr_q;
  logic              wr_next;
  logic              wr_status;
  logic              nn_zero;
  logic              nn_misaligned;

  assign wr_next       = reg_we && (reg_addr == REG_AW'(REG_NEXT));
  assign wr_status     = reg_we && (reg_addr == REG_AW'(REG_STATUS));
  assign nn_zero       = (next_node == '0);
  assign nn_misaligned = (next_node[ALIGN_BITS-1:0] != '0);
  assign start         = field_start && !busy && !nn_zero && !nn_misaligned;

  // next-node register with a held write during a fetch
  always_ff @(posedge clk) begin
    if (rst) begin
      next_node   <= '0;
      hold_q      <= 1'b0;
      hold_addr_q <= '0;
    end else begin
      if (wr_next && done) begin
        next_node <= reg_wdata[ADDR_W-1:0];
        hold_q    <= 1'b0;
      end else if (done) begin
        next_node <= hold_q ? hold_addr_q : link;
        hold_q    <= 1'b0;
      end else if (wr_next && busy) begin
        hold_q      <= 1'b1;
        hold_addr_q <= reg_wdata[ADDR_W-1:0];
      end else if (wr_next) begin
        next_node <= reg_wdata[ADDR_W-1:0];
      end
    end
  end

  // sticky misalignment flag, set wins over clear
  always_ff @(posedge clk) begin
    if (rst) begin
      err_q <= 1'b0;
    end else if (field_start && !busy && nn_misaligned) begin
      err_q <= 1'b1;
    end else if (wr_status && reg_wdata[ST_ERR]) begin
      err_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_addr == REG_AW'(REG_NEXT)) begin
      reg_rdata <= DATA_W'(next_node);
    end else if (reg_addr == REG_AW'(REG_STATUS)) begin
      reg_rdata <= DATA_W'({err_q, busy});
    end else begin
      reg_rdata <= '0;
    end
  end

  // R4
  err_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(err_q) |-> $past(field_start));

  // R10
  next_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_next && !done) |=> $stable(next_node));

endmodule

// File: rtl/pdf_fetch.sv
module pdf_fetch
  import pdf_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORDS      = 16,
  parameter int ALIGN_BITS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_base,
  input  logic              start_bottom,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DW-1:0]     mem_rsp_data,
  output logic              busy,
  output logic              done,
  output logic              tag_bottom,
  output plane_cfg_t        shadow,
  output logic [ADDR_W-1:0] link
);

  localparam int IDX_W = $clog2(WORDS);

  fetch_state_e      state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] base_q;
  logic [DW-1:0]     data_q;

  assign busy          = (state_q != F_IDLE);
  assign done          = (state_q == F_DONE);
  assign mem_req_valid = (state_q == F_ISSUE);
  assign mem_req_addr  = base_q + ADDR_W'({idx_q, 2'b00});

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= F_IDLE;
      idx_q      <= '0;
      base_q     <= '0;
      data_q     <= '0;
      tag_bottom <= 1'b0;
    end else begin
      case (state_q)
        F_IDLE: begin
          if (start) begin
            base_q     <= start_base;
            tag_bottom <= start_bottom;
            idx_q      <= '0;
            state_q    <= F_ISSUE;
          end
        end
        F_ISSUE: begin
          if (mem_req_ready) state_q <= F_WAIT;
        end
        F_WAIT: begin
          if (mem_rsp_valid) begin
            data_q  <= mem_rsp_data;
            state_q <= F_STORE;
          end
        end
        F_STORE: begin
          state_q <= F_ADVANCE;
        end
        F_ADVANCE: begin
          if (idx_q == IDX_W'(WORDS - 1)) begin
            state_q <= F_DONE;
          end else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= F_ISSUE;
          end
        end
        F_DONE: begin
          state_q <= F_IDLE;
        end
        default: state_q <= F_IDLE;
      endcase
    end
  end

  // shadow copy, written one word per store cycle, no reset needed
  always_ff @(posedge clk) begin
    if (state_q == F_STORE) begin
      case (int'(idx_q))
        W_CTRL:  shadow.ctrl   <= data_q;
        W_ALPHA: shadow.alpha  <= data_q;
        W_VPO:   shadow.origin <= data_q;
        W_VPS:   shadow.stop   <= data_q;
        W_PML:   shadow.base   <= data_q;
        W_PITCH: shadow.pitch  <= data_q;
        W_SIZE: begin
          shadow.height <= data_q[H_LSB +: DIM_W];
          shadow.width  <= data_q[DIM_W-1:0];
        end
        W_LINK:  link          <= data_q[ADDR_W-1:0];
        W_KEY1:  shadow.key1   <= data_q;
        W_KEY2:  shadow.key2   <= data_q;
        W_PROPS: shadow.props  <= data_q;
        W_CLUT:  shadow.clut   <= data_q;
        default: ;
      endcase
    end
  end

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R4
  base_ok_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> ((base_q[ALIGN_BITS-1:0] == '0) && (base_q != '0)));

endmodule

// File: rtl/pdf_active.sv
module pdf_active
  import pdf_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       done,
  input  logic       field_start,
  input  plane_cfg_t shadow,
  input  logic       tag_bottom,
  output plane_cfg_t cfg_q,
  output logic       enable_q,
  output logic       bottom_q
);

  logic defer;
  logic pend_q;
  logic commit;

  assign defer  = shadow.ctrl[DEFER_BIT];
  assign commit = (done && !defer) || (field_start && pend_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q    <= '0;
      enable_q <= 1'b0;
      bottom_q <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      if (commit) begin
        cfg_q    <= shadow;
        enable_q <= (shadow.props[IGN_W-1:0] == '0);
        bottom_q <= tag_bottom;
      end
      if (done && defer) begin
        pend_q <= 1'b1;
      end else if (field_start) begin
        pend_q <= 1'b0;
      end
    end
  end

  // R7
  atomic_chk: assert property (@(posedge clk) disable iff (rst)
    !commit |=> ($stable(cfg_q) && $stable(enable_q) && $stable(bottom_q)));

  // R8
  defer_chk: assert property (@(posedge clk) disable iff (rst)
    (done && defer && !(field_start && pend_q)) |=> $stable(cfg_q));

  // R9
  enable_chk: assert property (@(posedge clk) disable iff (rst)
    enable_q |-> (cfg_q.props[IGN_W-1:0] == '0));

endmodule

// File: rtl/plane_desc_fetch.sv
module plane_desc_fetch
  import pdf_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int REG_AW     = 8,
  parameter int DESC_WORDS = 16,
  parameter int ALIGN_BITS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic              field_start,
  input  logic              field_bottom,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DW-1:0]     mem_rsp_data,
  output logic [DW-1:0]     plane_ctrl,
  output logic [DW-1:0]     plane_alpha,
  output logic [DW-1:0]     plane_origin,
  output logic [DW-1:0]     plane_stop,
  output logic [DW-1:0]     plane_base,
  output logic [DW-1:0]     plane_pitch,
  output logic [DIM_W-1:0]  plane_height,
  output logic [DIM_W-1:0]  plane_width,
  output logic [DW-1:0]     plane_key1,
  output logic [DW-1:0]     plane_key2,
  output logic [DW-1:0]     plane_props,
  output logic [DW-1:0]     plane_clut,
  output logic              plane_enable,
  output logic              plane_bottom
);

  logic              busy;
  logic              done;
  logic              start;
  logic              tag_bottom;
  logic [ADDR_W-1:0] next_node;
  logic [ADDR_W-1:0] link;
  plane_cfg_t        shadow;
  plane_cfg_t        cfg;

  pdf_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DW), .REG_AW(REG_AW), .ALIGN_BITS(ALIGN_BITS)
  ) u_regs (
    .clk(clk), .rst(rst),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .field_start(field_start), .busy(busy), .done(done), .link(link),
    .next_node(next_node), .start(start)
  );

  pdf_fetch #(
    .ADDR_W(ADDR_W), .WORDS(DESC_WORDS), .ALIGN_BITS(ALIGN_BITS)
  ) u_fetch (
    .clk(clk), .rst(rst),
    .start(start), .start_base(next_node), .start_bottom(field_bottom),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data),
    .busy(busy), .done(done), .tag_bottom(tag_bottom),
    .shadow(shadow), .link(link)
  );

  pdf_active u_active (
    .clk(clk), .rst(rst),
    .done(done), .field_start(field_start),
    .shadow(shadow), .tag_bottom(tag_bottom),
    .cfg_q(cfg), .enable_q(plane_enable), .bottom_q(plane_bottom)
  );

  assign plane_ctrl   = cfg.ctrl;
  assign plane_alpha  = cfg.alpha;
  assign plane_origin = cfg.origin;
  assign plane_stop   = cfg.stop;
  assign plane_base   = cfg.base;
  assign plane_pitch  = cfg.pitch;
  assign plane_height = cfg.height;
  assign plane_width  = cfg.width;
  assign plane_key1   = cfg.key1;
  assign plane_key2   = cfg.key2;
  assign plane_props  = cfg.props;
  assign plane_clut   = cfg.clut;

endmodule

// File: tb/plane_desc_fetch_tb.sv
module plane_desc_fetch_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        reg_we;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        field_start;
  logic        field_bottom;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic [31:0] plane_ctrl, plane_alpha, plane_origin, plane_stop, plane_base, plane_pitch;
  logic [10:0] plane_height, plane_width;
  logic [31:0] plane_key1, plane_key2, plane_props, plane_clut;
  logic        plane_enable, plane_bottom;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  plane_desc_fetch u_dut (
    .clk(clk), .rst(rst),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .field_start(field_start), .field_bottom(field_bottom),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data),
    .plane_ctrl(plane_ctrl), .plane_alpha(plane_alpha), .plane_origin(plane_origin),
    .plane_stop(plane_stop), .plane_base(plane_base), .plane_pitch(plane_pitch),
    .plane_height(plane_height), .plane_width(plane_width),
    .plane_key1(plane_key1), .plane_key2(plane_key2), .plane_props(plane_props),
    .plane_clut(plane_clut), .plane_enable(plane_enable), .plane_bottom(plane_bottom)
  );

  // memory model: random acceptance and random response latency
  logic [31:0] mem [256];
  logic [31:0] req_log [1024];
  int          req_n = 0;
  int          overlap = 0;
  int          pend = 0;
  logic [31:0] paddr;
  logic        hs_prev = 1'b0;
  logic [31:0] hs_addr;

  initial begin
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
  end

  always @(negedge clk) begin
    mem_rsp_valid = 1'b0;
    if (pend > 0) begin
      pend = pend - 1;
      if (pend == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mem[paddr[9:2]];
      end
    end
    if (hs_prev) begin
      if (pend > 0 || mem_rsp_valid) overlap++;
      req_log[req_n] = hs_addr;
      req_n++;
      paddr = hs_addr;
      pend  = 1 + int'($urandom % 3);
    end
    mem_req_ready = ($urandom % 4) != 0;
    hs_prev = !rst && mem_req_valid && mem_req_ready;
    hs_addr = mem_req_addr;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic pulse(input logic b);
    @(negedge clk);
    field_start = 1'b1; field_bottom = b;
    @(negedge clk);
    field_start = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    bit ok = 0;
    for (int i = 0; i < 400; i++) begin
      rd(8'h00, s);
      if (!s[0]) begin ok = 1; break; end
    end
    chk("R12 fetch completes", 32'(ok), 32'd1);
  endtask

  task automatic build(input logic [31:0] a, input logic [31:0] lnk,
                       input logic defer, input logic [1:0] ign);
    int b = int'(a[9:2]);
    for (int i = 0; i < 16; i++) mem[b + i] = $urandom;
    mem[b][31]      = defer;
    mem[b + 9]      = lnk;
    mem[b + 13][1:0] = ign;
  endtask

  task automatic check_addrs(input int n0, input logic [31:0] base);
    chk("R2 request count", 32'(req_n - n0), 32'd16);
    for (int i = 0; i < 16; i++)
      chk("R2 request address", req_log[n0 + i], base + 32'(4 * i));
    chk("R2 single outstanding", 32'(overlap), 32'd0);
  endtask

  task automatic check_desc(input logic [31:0] a, input logic b);
    int i = int'(a[9:2]);
    chk("R6 ctrl",   plane_ctrl,   mem[i + 0]);
    chk("R6 alpha",  plane_alpha,  mem[i + 1]);
    chk("R6 origin", plane_origin, mem[i + 3]);
    chk("R6 stop",   plane_stop,   mem[i + 4]);
    chk("R6 base",   plane_base,   mem[i + 5]);
    chk("R6 pitch",  plane_pitch,  mem[i + 6]);
    chk("R6 height", 32'(plane_height), 32'(mem[i + 7][26:16]));
    chk("R6 width",  32'(plane_width),  32'(mem[i + 7][10:0]));
    chk("R6 key1",   plane_key1,   mem[i + 10]);
    chk("R6 key2",   plane_key2,   mem[i + 11]);
    chk("R6 props",  plane_props,  mem[i + 13]);
    chk("R6 clut",   plane_clut,   mem[i + 15]);
    chk("R9 enable", 32'(plane_enable), 32'(mem[i + 13][1:0] == 2'b00));
    chk("R13 field tag", 32'(plane_bottom), 32'(b));
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic [31:0] old_base;
    int n0;
    int bad;
    void'($urandom(32'h5EED_1234));
    rst = 1'b1; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    field_start = 1'b0; field_bottom = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 base", plane_base, 32'd0);
    chk("R1 ctrl", plane_ctrl, 32'd0);
    chk("R1 enable", 32'(plane_enable), 32'd0);
    chk("R1 bottom", 32'(plane_bottom), 32'd0);
    rd(8'h24, d); chk("R1 next-node", d, 32'd0);
    rd(8'h00, d); chk("R1 R12 status", d, 32'd0);

    // R3 empty chain
    n0 = req_n;
    pulse(1'b0);
    repeat (20) @(negedge clk);
    chk("R3 no request", 32'(req_n - n0), 32'd0);
    chk("R3 outputs hold", plane_base, 32'd0);

    // R4 misaligned address
    wr(8'h24, 32'h0000_0104);
    pulse(1'b0);
    repeat (20) @(negedge clk);
    chk("R4 no request", 32'(req_n - n0), 32'd0);
    rd(8'h00, d); chk("R4 error set", d, 32'd2);
    wr(8'h00, 32'd2);
    rd(8'h00, d); chk("R4 error cleared", d, 32'd0);

    // R5 two descriptors linked into a loop
    build(32'h100, 32'h140, 1'b0, 2'b00);
    build(32'h140, 32'h100, 1'b0, 2'b01);
    wr(8'h24, 32'h100);
    rd(8'h24, d); chk("R12 next-node readback", d, 32'h100);
    n0 = req_n;
    pulse(1'b0);
    wait_idle();
    check_addrs(n0, 32'h100);
    check_desc(32'h100, 1'b0);
    rd(8'h24, d); chk("R5 follow link", d, 32'h140);
    n0 = req_n;
    pulse(1'b1);
    wait_idle();
    check_addrs(n0, 32'h140);
    check_desc(32'h140, 1'b1);
    rd(8'h24, d); chk("R5 loop back", d, 32'h100);

    // R7 R10 R11 redirect and extra event during a fetch
    build(32'h180, 32'h0, 1'b1, 2'b00);
    old_base = plane_base;
    bad = 0;
    n0 = req_n;
    pulse(1'b0);
    repeat (3) begin
      @(negedge clk);
      if (plane_base !== old_base) bad++;
    end
    wr(8'h24, 32'h180);
    pulse(1'b1);
    while (req_n < n0 + 16) begin
      @(negedge clk);
      if (plane_base !== old_base) bad++;
    end
    chk("R7 no partial update", 32'(bad), 32'd0);
    wait_idle();
    chk("R11 single fetch", 32'(req_n - n0), 32'd16);
    check_desc(32'h100, 1'b0);
    rd(8'h24, d); chk("R10 held write used", d, 32'h180);

    // R8 deferred commit
    n0 = req_n;
    pulse(1'b1);
    wait_idle();
    check_addrs(n0, 32'h180);
    chk("R8 deferred, base unchanged", plane_base, mem[(32'h100 >> 2) + 5]);
    chk("R8 deferred, ctrl unchanged", plane_ctrl, mem[(32'h100 >> 2) + 0]);
    rd(8'h24, d); chk("R5 end of chain", d, 32'h0);
    n0 = req_n;
    pulse(1'b0);
    check_desc(32'h180, 1'b1);
    chk("R8 commit on field start", plane_ctrl[31], 1'b1);
    repeat (10) @(negedge clk);
    chk("R3 stopped chain", 32'(req_n - n0), 32'd0);

    // random descriptors with a size corner case first
    for (int r = 0; r < 8; r++) begin
      logic [31:0] a;
      logic        b;
      a = 32'h200 + 32'(($urandom % 8) * 'h40);
      b = 1'($urandom % 2);
      build(a, 32'h0, 1'b0, 2'($urandom % 4));
      if (r == 0) mem[a[9:2] + 7] = 32'hFFFF_FFFF;
      wr(8'h24, a);
      n0 = req_n;
      pulse(b);
      wait_idle();
      check_addrs(n0, a);
      check_desc(a, b);
      if (r == 0) chk("R6 max size", {5'd0, plane_height, 5'd0, plane_width}, {5'd0, 11'h7FF, 5'd0, 11'h7FF});
      rd(8'h24, d); chk("R5 random link", d, 32'h0);
    end

    finish_run();
  end

endmodule